// File: doc/BRIEF.md
# Thermostat Alarm Output Controller

This block decides the level of a thermostat alarm pin. Each time the temperature converter finishes, it presents a 16-bit two's complement sample together with a one-cycle done strobe. The block compares that sample against two stored limits: an upper trip limit and a lower release (hysteresis) limit. It asserts the alarm only after a programmable run of consecutive qualifying samples. The comparison is truncated to the active converter resolution, so the fractional bits that the converter does not produce are ignored in the sample and in both limits.

Two behaviours are selectable. In level-following (comparator) mode, the alarm tracks the temperature band with hysteresis. In event (interrupt) mode, the alarm latches on an event and stays set until it is acknowledged by a register-read pulse or by entering shutdown. The event that can fire next alternates between "above the upper limit" and "below the release limit". The output polarity is selectable, so the pin can drive an open-drain stage that is either active-low or active-high. Both limits are held in internal registers that have reset values. A simple write strobe loads them.

Top module: `therm_alarm`

## Requirements
- R1: After reset the upper limit is 0x5000 and the release limit is 0x4B00, the internal alarm is inactive and the event mode expects an upper-limit event. With polHigh=0 the pin `alarmOut` reads 1 (inactive) after reset.
- R2: The 2-bit fault code `faultCode` sets how many consecutive qualifying samples assert the alarm: 00 means 1, 01 means 2, 10 means 4 and 11 means 6.
- R3: With intMode=0, the alarm asserts after the required run of samples above the upper limit. It deasserts on the first sample below the release limit, with no run count for the release.
- R4: With intMode=1, the first assertion needs a run of samples above the upper limit. After each clear, the next assertion needs a run of samples below the release limit. The expected event then keeps alternating. While the alarm is asserted in this mode, no samples are counted.
- R5: With intMode=1, a `readPulse` clears an asserted alarm on the next clock edge. With intMode=0, `readPulse` has no effect.
- R6: While `shutdown` is 1, samples are ignored. In intMode=1 the alarm is cleared, and in intMode=0 it keeps its level.
- R7: Comparisons use only the top 9+resCode bits of the sample and of both limits. resCode is 00 for 9 bits, 01 for 10, 10 for 11 and 11 for 12, and the lower bits are treated as zero.
- R8: With polHigh=0 the output is active-low (alarm gives 0), and with polHigh=1 it is active-high (alarm gives 1).
- R9: A sample that does not meet the condition being counted resets the run count to zero. The count also restarts whenever the alarm changes state or is cleared.
- R10: A sample equal to a limit is neither above the upper limit nor below the release limit.
- R11: When a sample that completes a run arrives in the same cycle as a `readPulse`, the alarm asserts.
- R12: A `limWr` pulse loads `limData` into the upper limit when limSel=1 and into the release limit when limSel=0. A sample presented in the same cycle is compared against the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| convDone | input | 1 | One-cycle strobe: `sample` holds a new conversion |
| sample | input | 16 | Two's complement temperature sample |
| resCode | input | 2 | Active resolution code (9 to 12 bits) |
| faultCode | input | 2 | Consecutive-sample run length code |
| polHigh | input | 1 | 1 = active-high output, 0 = active-low |
| intMode | input | 1 | 1 = event (interrupt) mode, 0 = comparator mode |
| shutdown | input | 1 | Shutdown level |
| readPulse | input | 1 | One-cycle register-read acknowledge |
| limWr | input | 1 | Limit write strobe |
| limSel | input | 1 | 1 = upper limit, 0 = release limit |
| limData | input | 16 | Limit value to write |
| alarmOut | output | 1 | Alarm pin level after polarity |

## Verification
The bench builds the block with its default parameters: a 16-bit word and a 9-bit base resolution. These defaults make all four resolution codes reachable, including the 9-bit case, where a sample such as 0x5070 falls onto the upper limit itself. The 3-bit run counter can reach a run of six samples. A fixed-seed random phase reconfigures mode, polarity, resolution, run length and limits while sweeping samples across both limits. This mix brings mode changes with a latched alarm, reads that coincide with conversions, and shutdown during an unfinished run within reach.

// File: rtl/therm_alarm_pkg.sv
package therm_alarm_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic cntInc;
    logic cntClr;
  } ctlStrobe_t;

  // comparison results from datapath to control
  typedef struct packed {
    logic aboveHi;
    logic belowLo;
    logic hitNext;
  } cmpFlags_t;
endpackage

// File: rtl/therm_cmp_dp.sv
module therm_cmp_dp
  import therm_alarm_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int RES_BASE = 9,
  parameter int CNT_W = 3,
  parameter logic [WORD_W-1:0] HI_RESET = 16'h5000,
  parameter logic [WORD_W-1:0] LO_RESET = 16'h4B00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] sample,
  input  logic [1:0]        resCode,
  input  logic [1:0]        faultCode,
  input  logic              limWr,
  input  logic              limSel,
  input  logic [WORD_W-1:0] limData,
  input  ctlStrobe_t        strobe,
  output cmpFlags_t         flags
);
  localparam int RES_TOP = WORD_W - RES_BASE;
  localparam int SH_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] hiReg, loReg;
  logic [CNT_W-1:0]  cnt;
  logic [SH_W-1:0]   dropBits;
  logic [WORD_W-1:0] resMask;
  logic signed [WORD_W-1:0] sampleT, hiT, loT;
  logic [CNT_W:0] need, cntPlus;

  // limit registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiReg <= HI_RESET;
      loReg <= LO_RESET;
    end else if (limWr) begin
      if (limSel) hiReg <= limData;
      else        loReg <= limData;
    end
  end

  // resolution truncation
  always_comb begin
    dropBits = SH_W'(RES_TOP) - SH_W'(resCode);
    resMask  = {WORD_W{1'b1}} << dropBits;
    sampleT  = sample & resMask;
    hiT      = hiReg & resMask;
    loT      = loReg & resMask;
  end

  // run length decode
  always_comb begin
    unique case (faultCode)
      2'b00:   need = (CNT_W+1)'(1);
      2'b01:   need = (CNT_W+1)'(2);
      2'b10:   need = (CNT_W+1)'(4);
      default: need = (CNT_W+1)'(6);
    endcase
    cntPlus = {1'b0, cnt} + (CNT_W+1)'(1);
  end

  assign flags.aboveHi = sampleT > hiT;
  assign flags.belowLo = sampleT < loT;
  assign flags.hitNext = cntPlus >= need;

  // consecutive-sample counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strobe.cntClr) cnt <= '0;
    else if (strobe.cntInc) cnt <= cnt + CNT_W'(1);
  end

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntInc && !strobe.cntClr |=> cnt == $past(cnt) + CNT_W'(1));
  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(5));
  // R9
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntClr |=> cnt == '0);
endmodule

// File: rtl/therm_alarm_ctl.sv
module therm_alarm_ctl
  import therm_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       convDone,
  input  logic       shutdown,
  input  logic       readPulse,
  input  logic       intMode,
  input  cmpFlags_t  flags,
  output ctlStrobe_t strobe,
  output logic       alarmQ
);
  logic expLo;
  logic sampleOk, countCond, fire, compRelease, intClear;

  always_comb begin
    sampleOk    = convDone && !shutdown;
    countCond   = intMode ? (expLo ? flags.belowLo : flags.aboveHi) : flags.aboveHi;
    fire        = sampleOk && !alarmQ && countCond && flags.hitNext;
    compRelease = sampleOk && alarmQ && !intMode && flags.belowLo;
    intClear    = alarmQ && intMode && (readPulse || shutdown);
    strobe.cntInc = sampleOk && !alarmQ && countCond && !flags.hitNext;
    strobe.cntClr = alarmQ || fire || (sampleOk && !countCond);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmQ <= 1'b0;
      expLo  <= 1'b0;
    end else begin
      if (fire) alarmQ <= 1'b1;
      else if (compRelease || intClear) alarmQ <= 1'b0;
      if (!intMode) expLo <= 1'b0;
      else if (fire) expLo <= ~expLo;
    end
  end

  // R3
  comp_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(alarmQ) && !$past(intMode) |-> $past(convDone) && !$past(shutdown));
  // R6
  shut_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    alarmQ && intMode && shutdown |=> !alarmQ);
  // R5
  comp_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    alarmQ && !intMode && readPulse && !convDone |=> alarmQ);
  // R11
  rise_on_sample_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmQ) |-> $past(convDone) && !$past(shutdown));
endmodule

// File: rtl/therm_alarm.sv
module therm_alarm
  import therm_alarm_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int RES_BASE = 9,
  parameter logic [WORD_W-1:0] HI_RESET = 16'h5000,
  parameter logic [WORD_W-1:0] LO_RESET = 16'h4B00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              convDone,
  input  logic [WORD_W-1:0] sample,
  input  logic [1:0]        resCode,
  input  logic [1:0]        faultCode,
  input  logic              polHigh,
  input  logic              intMode,
  input  logic              shutdown,
  input  logic              readPulse,
  input  logic              limWr,
  input  logic              limSel,
  input  logic [WORD_W-1:0] limData,
  output logic              alarmOut
);
  localparam int CNT_W = 3;

  ctlStrobe_t strobe;
  cmpFlags_t  flags;
  logic       alarmQ;

  therm_cmp_dp #(
    .WORD_W(WORD_W), .RES_BASE(RES_BASE), .CNT_W(CNT_W),
    .HI_RESET(HI_RESET), .LO_RESET(LO_RESET)
  ) i_dp (
    .clk(clk), .rstN(rstN), .sample(sample), .resCode(resCode),
    .faultCode(faultCode), .limWr(limWr), .limSel(limSel),
    .limData(limData), .strobe(strobe), .flags(flags)
  );

  therm_alarm_ctl i_ctl (
    .clk(clk), .rstN(rstN), .convDone(convDone), .shutdown(shutdown),
    .readPulse(readPulse), .intMode(intMode), .flags(flags),
    .strobe(strobe), .alarmQ(alarmQ)
  );

  assign alarmOut = polHigh ? alarmQ : ~alarmQ;
endmodule

// File: tb/test_therm_alarm.sv
module test_therm_alarm;
  logic clk = 0;
  logic rstN = 0;
  logic convDone = 0, polHigh = 0, intMode = 0, shutdown = 0, readPulse = 0;
  logic limWr = 0, limSel = 0;
  logic [15:0] sample = 0, limData = 0;
  logic [1:0] resCode = 0, faultCode = 0;
  logic alarmOut;

  int nChecks = 0, nFails = 0;
  logic mAlarm, mExpLo;
  int mCnt;
  logic [15:0] mHi, mLo;

  always #4 clk = ~clk;

  therm_alarm i_therm_alarm (
    .clk(clk), .rstN(rstN), .convDone(convDone), .sample(sample),
    .resCode(resCode), .faultCode(faultCode), .polHigh(polHigh),
    .intMode(intMode), .shutdown(shutdown), .readPulse(readPulse),
    .limWr(limWr), .limSel(limSel), .limData(limData), .alarmOut(alarmOut)
  );

  function automatic logic [15:0] resMask(input logic [1:0] r);
    return 16'hFFFF << (7 - int'(r));
  endfunction

  function automatic int runLen(input logic [1:0] f);
    case (f)
      2'b00: return 1;
      2'b01: return 2;
      2'b10: return 4;
      default: return 6;
    endcase
  endfunction

  // spec model, applied for the edge that follows the driven inputs
  task automatic modelStep();
    logic [15:0] m;
    logic above, below, cond, ok, fire, rel, clr;
    m = resMask(resCode);
    above = $signed(sample & m) > $signed(mHi & m);
    below = $signed(sample & m) < $signed(mLo & m);
    ok = convDone && !shutdown;
    cond = intMode ? (mExpLo ? below : above) : above;
    fire = ok && !mAlarm && cond && (mCnt + 1 >= runLen(faultCode));
    rel = ok && mAlarm && !intMode && below;
    clr = mAlarm && intMode && (readPulse || shutdown);
    if (fire || mAlarm) mCnt = 0;
    else if (ok) mCnt = cond ? mCnt + 1 : 0;
    if (!intMode) mExpLo = 0;
    else if (fire) mExpLo = ~mExpLo;
    if (fire) mAlarm = 1;
    else if (rel || clr) mAlarm = 0;
    if (limWr) begin
      if (limSel) mHi = limData;
      else mLo = limData;
    end
  endtask

  task automatic check(input string tag);
    logic expv;
    expv = polHigh ? mAlarm : ~mAlarm;
    nChecks++;
    if (alarmOut !== expv) begin
      nFails++;
      $display("FAIL %s: alarmOut=%b expected %b at %0t", tag, alarmOut, expv, $time);
    end
  endtask

  // one cycle: drive at negedge, model, wait an edge, check at next negedge
  task automatic cyc(input logic cd, input logic [15:0] smp, input logic rd,
                     input string tag);
    convDone = cd; sample = smp; readPulse = rd;
    modelStep();
    @(posedge clk);
    @(negedge clk);
    convDone = 0; readPulse = 0; limWr = 0;
    check(tag);
  endtask

  task automatic wrLim(input logic sel, input logic [15:0] d, input string tag);
    limWr = 1; limSel = sel; limData = d;
    cyc(0, 16'h0, 0, tag);
  endtask

  initial begin
    #(8 * 150000);
    nFails++;
    $display("FAIL watchdog: alarmOut=%b expected completion", alarmOut);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    mAlarm = 0; mExpLo = 0; mCnt = 0; mHi = 16'h5000; mLo = 16'h4B00;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 reset level");

    // comparator mode, run of one
    cyc(1, 16'h5000, 0, "R10 equal to upper limit");
    cyc(1, 16'h5080, 0, "R3 assert above limit");
    cyc(1, 16'h4B00, 0, "R10 equal to release limit");
    cyc(1, 16'h4C00, 0, "R3 inside band holds");
    cyc(0, 16'h0, 1, "R5 read ignored in comparator");
    shutdown = 1;
    cyc(1, 16'h4000, 0, "R6 shutdown keeps comparator level");
    shutdown = 0;
    cyc(1, 16'h4A00, 0, "R3 release on first low sample");

    // run lengths
    faultCode = 2'b01;
    cyc(1, 16'h5100, 0, "R2 run of two, first");
    cyc(1, 16'h4F00, 0, "R9 broken run");
    cyc(1, 16'h5100, 0, "R9 run restarted");
    cyc(1, 16'h5100, 0, "R2 run of two completes");
    cyc(1, 16'h4000, 0, "R3 release");
    faultCode = 2'b11;
    for (int i = 0; i < 6; i++) cyc(1, 16'h6000, 0, "R2 run of six");
    polHigh = 1;
    @(negedge clk); check("R8 active-high polarity");
    cyc(1, 16'h4000, 0, "R8 release active-high");
    polHigh = 0;

    // event mode
    faultCode = 2'b00; intMode = 1;
    cyc(1, 16'h5100, 0, "R4 first upper event");
    cyc(1, 16'h5100, 0, "R4 held while latched");
    cyc(0, 16'h0, 1, "R5 read clears");
    cyc(1, 16'h5100, 0, "R4 upper ignored after clear");
    cyc(1, 16'h4A00, 0, "R4 release event");
    cyc(0, 16'h0, 1, "R5 read clears again");
    cyc(1, 16'h4A00, 0, "R4 low ignored after clear");
    cyc(1, 16'h5100, 0, "R4 upper event again");
    shutdown = 1;
    cyc(0, 16'h0, 0, "R6 shutdown clears event");
    cyc(1, 16'h4000, 0, "R6 samples ignored in shutdown");
    shutdown = 0;
    cyc(1, 16'h4000, 1, "R11 read with firing sample");
    cyc(0, 16'h0, 1, "R5 clear after R11");
    intMode = 0;

    // resolution truncation
    resCode = 2'b00;
    cyc(1, 16'h5070, 0, "R7 9-bit drops fraction");
    resCode = 2'b11;
    cyc(1, 16'h5070, 0, "R7 12-bit sees fraction");
    cyc(1, 16'h4000, 0, "R7 release");
    resCode = 2'b00;

    // limit writes
    limWr = 1; limSel = 1; limData = 16'h1000;
    cyc(1, 16'h2000, 0, "R12 same-cycle sample uses old limit");
    wrLim(0, 16'h0800, "R12 write release limit");
    cyc(1, 16'h1080, 0, "R12 new upper limit");
    cyc(1, 16'h0800, 0, "R12 equal new release");
    cyc(1, 16'h0780, 0, "R12 below new release");
    wrLim(1, 16'h5000, "R12 restore upper");
    wrLim(0, 16'h4B00, "R12 restore release");

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      if (n % 150 == 0) begin
        resCode = 2'($urandom); faultCode = 2'($urandom);
        polHigh = 1'($urandom); intMode = 1'($urandom);
      end
      if ($urandom % 40 == 0) shutdown = ~shutdown;
      if ($urandom % 100 == 0) begin
        limWr = 1; limSel = 1'($urandom);
        limData = limSel ? 16'h4E00 + 16'($urandom % 16'h0400)
                         : 16'h4900 + 16'($urandom % 16'h0400);
      end
      cyc(1'($urandom), 16'h4600 + 16'($urandom % 16'h1400),
          ($urandom % 10) == 0, "R4 random mix");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule